// File: doc/BRIEF.md
# Stretchable External Data-Memory Bus Sequencer

This block runs one external data-memory read or write on a multiplexed bus. The low address byte and the data share one port. The high address byte has a port of its own. An address latch strobe marks the phase in which the multiplexed port carries the low address byte. Two active-low strobes, one for read and one for write, frame the data transfer. A request carries a 16-bit address, a direction bit and write data. A 3-bit stretch selector lengthens the access in whole machine cycles. When the access ends, the block reports the read data and a one-cycle completion pulse.

Every clock cycle of `clk` is one timing tick, equal to half an oscillator clock. A machine cycle is therefore 8 ticks. Tick numbers below count from the first busy cycle after a request is accepted; that cycle is tick 0. Stretch selector value `s` gives an access of `L = (2+s)*8` ticks. A nonzero `s` also moves the strobe's falling edge later and widens the write-data hold after the strobe rises. The request side uses valid/ready. `req_ready` is high exactly when the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Holding `req_valid` high while `req_ready` is low has no effect. The completion side has no back-pressure: `done` is a one-cycle pulse with `rdata`, and the consumer must take it in that cycle.

Top module: `xbus_seq`

## Requirements
- R1: An access with selector value s keeps the block busy for exactly L=(2+s)*8 ticks (ticks 0..L-1). `done` is high for exactly one cycle, in tick L, and `req_ready` returns high in that same cycle.
- R2: `ale` is high in ticks 0 and 1 and low for the rest of the access. The active strobe falls at tick 3 when s=0 and at tick 5 when s is nonzero. That leaves 1 tick (s=0) or 3 ticks (s nonzero) between the falling edge of `ale` and the falling edge of the strobe.
- R3: `p2_out` carries address bits 15:8 in every tick of the access. It is therefore stable at least 3 ticks (s=0) or 5 ticks (s nonzero) before the strobe falls.
- R4: For a write, `p0_oe` is 1 and `p0_out` carries the write data from tick 3 to tick L-1. With s nonzero, the data is therefore valid 2 ticks before `wr_n` falls.
- R5: The active strobe rises at tick L-2 when s=0 and at tick L-4 when s is nonzero. For a write, the data stays driven for 2 or 4 ticks after `wr_n` rises. The next `ale` can rise no earlier than tick L+1, so recovery before it is at least 3 ticks when s=0 and at least 5 ticks when s is nonzero.
- R6: In ticks 0 and 1, `p0_oe` is 1 and `p0_out` carries address bits 7:0. For a read, `p0_oe` is 0 from tick 2 to the end of the access, before `rd_n` falls.
- R7: For a read, `rdata` shows the value that `p0_in` had in the last tick in which `rd_n` is low (tick L-3 or L-5). `rdata` holds that value until the next read sample.
- R8: The selector is latched when a request is accepted. Changing `stretch_sel` during an access does not change that access's timing.
- R9: While busy, `req_ready` is 0, and a held `req_valid` starts no access and does not change `p2_out`.
- R10: `rd_n` and `wr_n` are never low together, and only the strobe that matches the direction goes low. After reset, `rd_n`=`wr_n`=1, `ale`=0, `done`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one cycle per half oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | High when idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| stretch_sel | input | 3 | Stretch selector, sampled at accept |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Captured read data |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| p0_out | output | 8 | Multiplexed port output value |
| p0_oe | output | 1 | Multiplexed port drive enable |
| p0_in | input | 8 | Multiplexed port input value |
| p2_out | output | 8 | High address byte |

## Verification
All of the block's timing is counted in ticks from the first cycle in which `ale` is high. The `done` pulse is due at tick L = (2+s)*8. The strobe edges are due at ticks 3 or 5 and L-2 or L-4, and the read sample is taken at the tick before the strobe rises. The monitor samples at falling clock edges and numbers the ticks of each access from the `ale` rise. It compares every event against the tick that the scoreboard item's selector predicts, not against the live selector. To prove that the sample is taken in the right tick, it drives the expected read byte on `p0_in` only in tick R-1 and the inverted byte in every other tick.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  // Tick positions within an access (one tick = half oscillator clock)
  localparam int ALE_TICKS    = 2;  // ale high in ticks 0..ALE_TICKS-1
  localparam int DATA_TICK    = 3;  // first tick carrying write data
  localparam int FALL_PLAIN   = 3;  // strobe fall tick, no stretch
  localparam int FALL_STRETCH = 5;  // strobe fall tick, stretched
  localparam int HOLD_PLAIN   = 2;  // ticks from strobe rise to access end
  localparam int HOLD_STRETCH = 4;

  typedef enum logic {DIR_RD = 1'b0, DIR_WR = 1'b1} xbus_dir_e;

  function automatic int fall_tick(input logic stretched);
    return stretched ? FALL_STRETCH : FALL_PLAIN;
  endfunction

  function automatic int hold_ticks(input logic stretched);
    return stretched ? HOLD_STRETCH : HOLD_PLAIN;
  endfunction
endpackage

// File: rtl/xbus_phase_ctr.sv
module xbus_phase_ctr #(
  parameter int SEL_W    = 3,
  parameter int MC_TICKS = 8,
  parameter int CNT_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SEL_W-1:0] sel_in,
  output logic             busy,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] len,
  output logic [SEL_W-1:0] sel_q,
  output logic             last
);
  assign len  = CNT_W'((32'(sel_q) + 32'd2) * 32'(MC_TICKS));
  assign last = busy && (cnt == len - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      sel_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt   <= '0;
      sel_q <= sel_in;
    end else if (busy) begin
      if (last) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last |=> busy && cnt == $past(cnt) + CNT_W'(1));
  // R8
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last |=> sel_q == $past(sel_q));
endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
  import xbus_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] len,
  input  logic [SEL_W-1:0] sel_q,
  input  logic             is_wr,
  output logic             ale,
  output logic             rd_n,
  output logic             wr_n,
  output logic             p0_oe,
  output logic             data_phase,
  output logic             sample_now
);
  logic             stretched;
  logic [CNT_W-1:0] fall_at;
  logic [CNT_W-1:0] rise_at;
  logic             strobe_low;

  always_comb begin
    stretched  = |sel_q;
    fall_at    = CNT_W'(fall_tick(stretched));
    rise_at    = len - CNT_W'(hold_ticks(stretched));
    strobe_low = busy && (cnt >= fall_at) && (cnt < rise_at);
    ale        = busy && (cnt < CNT_W'(ALE_TICKS));
    rd_n       = !(strobe_low && !is_wr);
    wr_n       = !(strobe_low && is_wr);
    p0_oe      = busy && (is_wr || (cnt < CNT_W'(ALE_TICKS)));
    data_phase = cnt >= CNT_W'(DATA_TICK);
    sample_now = busy && !is_wr && (cnt == rise_at - CNT_W'(1));
  end

  // R2
  ale_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_n) || $fell(wr_n)) |-> !ale && !$past(ale));
  // R6
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !p0_oe);
endmodule

// File: rtl/xbus_rd_capture.sv
module xbus_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (sample) rdata <= bus_in;
  end

  // R7
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample |=> $stable(rdata));
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int SEL_W    = 3,
  parameter int MC_TICKS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [SEL_W-1:0]         stretch_sel,
  output logic                     done,
  output logic [DATA_W-1:0]        rdata,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [DATA_W-1:0]        p0_out,
  output logic                     p0_oe,
  input  logic [DATA_W-1:0]        p0_in,
  output logic [ADDR_W-DATA_W-1:0] p2_out
);
  localparam int HI_W    = ADDR_W - DATA_W;
  localparam int MAX_LEN = ((1 << SEL_W) + 1) * MC_TICKS;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic              busy, last, accept, data_phase, sample_now;
  logic [CNT_W-1:0]  cnt, len;
  logic [SEL_W-1:0]  sel_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  xbus_dir_e         dir_q;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      dir_q   <= DIR_RD;
      done    <= 1'b0;
    end else begin
      done <= last;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        dir_q   <= req_write ? DIR_WR : DIR_RD;
      end
    end
  end

  xbus_phase_ctr #(.SEL_W(SEL_W), .MC_TICKS(MC_TICKS), .CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .start(accept), .sel_in(stretch_sel),
    .busy(busy), .cnt(cnt), .len(len), .sel_q(sel_q), .last(last)
  );

  xbus_strobe_gen #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_strb (
    .clk(clk), .rst_n(rst_n), .busy(busy), .cnt(cnt), .len(len),
    .sel_q(sel_q), .is_wr(dir_q == DIR_WR), .ale(ale), .rd_n(rd_n),
    .wr_n(wr_n), .p0_oe(p0_oe), .data_phase(data_phase),
    .sample_now(sample_now)
  );

  xbus_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .sample(sample_now), .bus_in(p0_in),
    .rdata(rdata)
  );

  assign p0_out = data_phase ? wdata_q : addr_q[DATA_W-1:0];
  assign p2_out = addr_q[ADDR_W-1 -: HI_W];

  // R10
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready && $past(busy) ##1 !done);
  // R3
  hi_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(p2_out));
  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last |=> busy && !$rose(ale));
endmodule

// File: tb/tb_xbus_seq.sv
module tb_xbus_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, p0_in = '0;
  logic [2:0]  stretch_sel = '0;
  logic        req_ready, done, ale, rd_n, wr_n, p0_oe;
  logic [7:0]  rdata, p0_out, p2_out;

  int checks = 0, errors = 0;

  typedef struct {
    bit wr;
    logic [15:0] addr;
    logic [7:0] data;
    int sel;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;  // 50 MHz

  xbus_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .stretch_sel(stretch_sel), .done(done), .rdata(rdata), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .p0_out(p0_out), .p0_oe(p0_oe),
    .p0_in(p0_in), .p2_out(p2_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Driver: pushes the expected item, then hands the request to the DUT
  task automatic issue(input bit wr, input logic [15:0] addr, input logic [7:0] data,
                       input int sel, input bit poke);
    item_t it;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    it.wr = wr; it.addr = addr; it.data = data; it.sel = sel;
    q.push_back(it);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = data;
    stretch_sel = 3'(sel);
    @(negedge clk);
    req_valid = 1'b0;
    stretch_sel = ~3'(sel);  // R8: must not affect the running access
    if (poke) begin
      req_valid = 1'b1; req_addr = ~addr; req_write = ~wr;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        // R9: ready low, high byte unchanged
        check(!req_ready && p2_out == addr[15:8], "R9 busy ignore",
              int'(p2_out), int'(addr[15:8]));
      end
      req_valid = 1'b0;
    end
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor / scoreboard
  initial begin
    bit active = 0;
    int idx = 0, fall_i = -1, rise_i = -1, L = 0, R = 0, F = 0;
    bit ale_ok, p2_ok, lo_ok, wd_ok, rel_ok, pair_ok;
    item_t cur;
    forever begin
      @(negedge clk);
      if (!rst_n) continue;
      if (active) idx++;
      else if (ale) begin
        active = 1; idx = 0; fall_i = -1; rise_i = -1;
        ale_ok = 1; p2_ok = 1; lo_ok = 1; wd_ok = 1; rel_ok = 1; pair_ok = 1;
        if (q.size() == 0) begin
          check(0, "R9 unexpected access", 1, 0);
          cur.wr = 0; cur.addr = 0; cur.data = 0; cur.sel = 0;
        end else cur = q[0];
        L = (2 + cur.sel) * 8;
        R = L - ((cur.sel != 0) ? 4 : 2);
        F = (cur.sel != 0) ? 5 : 3;
      end
      if (done) begin
        if (!active) check(0, "R1 done without access", 0, 1);
        else begin
          check(idx == L, "R1 R8 access length", idx, L);
          check(req_ready, "R1 ready at done", int'(req_ready), 1);
          check(ale_ok && fall_i == F, "R2 ale and strobe fall", fall_i, F);
          check(p2_ok, "R3 high address", 0, 1);
          check(rise_i == R, "R5 strobe rise", rise_i, R);
          check(lo_ok, "R6 low address phase", 0, 1);
          check(pair_ok, "R10 strobe pairing", 0, 1);
          if (cur.wr) check(wd_ok, "R4 R5 write data drive and hold", 0, 1);
          else begin
            check(rel_ok, "R6 read release", 0, 1);
            check(rdata == cur.data, "R7 read data", int'(rdata), int'(cur.data));
          end
          void'(q.pop_front());
        end
        active = 0;
      end else if (active) begin
        bit strb, other;
        strb  = cur.wr ? wr_n : rd_n;
        other = cur.wr ? rd_n : wr_n;
        if (ale != (idx < 2)) ale_ok = 0;
        if (p2_out != cur.addr[15:8]) p2_ok = 0;
        if (!other) pair_ok = 0;
        if (!strb && fall_i < 0) fall_i = idx;
        if (strb && fall_i >= 0 && rise_i < 0) rise_i = idx;
        if (idx < 2 && !(p0_oe && p0_out == cur.addr[7:0])) lo_ok = 0;
        if (cur.wr && idx >= 3 && !(p0_oe && p0_out == cur.data)) wd_ok = 0;
        if (!cur.wr && idx >= 2 && p0_oe) rel_ok = 0;
        p0_in = (idx == R - 1) ? cur.data : ~cur.data;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R10: reset state
    check(rd_n && wr_n && !ale && !done && req_ready, "R10 reset state",
          int'({rd_n, wr_n, ale, done, req_ready}), 5'b11001);
    rst_n = 1'b1;
    @(negedge clk);
    issue(0, 16'h12A5, 8'h3C, 0, 0);
    drain();
    issue(1, 16'hBE01, 8'hC7, 0, 0);
    drain();
    issue(0, 16'h4F80, 8'h96, 1, 0);
    drain();
    issue(1, 16'h7702, 8'h5A, 1, 1);
    drain();
    issue(0, 16'hF00F, 8'hE1, 7, 0);
    drain();
    issue(1, 16'h0155, 8'h0F, 7, 0);
    drain();
    issue(0, 16'hA3C4, 8'h71, 3, 1);
    drain();
    // back-to-back
    issue(1, 16'h2468, 8'hAA, 2, 0);
    issue(0, 16'h1357, 8'h55, 0, 0);
    issue(1, 16'hFFFF, 8'h00, 4, 0);
    drain();
    check(rd_n && wr_n && !ale && req_ready, "R10 idle after traffic",
          int'({rd_n, wr_n, ale, req_ready}), 4'b1101);
    finish_run();
  end
endmodule